// File: doc/BRIEF.md
# Palette Load and Pixel Lookup Unit

This block owns the colour palette of a display pipeline. After the unit is enabled, it takes 32-bit words from a stream input that has a valid/ready handshake. Each word carries two 16-bit colour entries. The unit writes the entries into an internal 256 x 16 palette memory. Once the palette is in place, it accepts encoded pixel indices and returns the 16-bit colour held at each index, one cycle later.

A three-bit depth setting controls two things: how many entries a load writes, and how many index bits a lookup uses. At the direct (16-bit) depth the palette is bypassed entirely. No load takes place, and the pixel value itself comes out as the colour.

Pixels are refused until the first load of an enabled period has finished. After that, a new load can be requested at any frame start with a reload flag. The depth setting is captured only while the block is disabled. Changing it therefore always goes through a disable, and the following enable requires a fresh load.

Top module: `pal_lut_unit`

## Requirements
- R1: `depth_sel` encodes 0 = 1 bpp, 1 = 2 bpp, 2 = 4 bpp, 3 = 8 bpp, and 4 to 7 = direct 16 bpp. The active depth follows `depth_sel` while `en` is low and stays frozen while `en` is high.
- R2: A load starts at the first `frame_start` after enabling, for a non-direct depth. It accepts exactly 2 words at 1 or 2 bpp, 8 words at 4 bpp and 128 words at 8 bpp. `wd_ready` is high exactly while a load is in progress.
- R3: The k-th accepted word of a load (k counted from 0) writes entry 2k from bits 15:0 and entry 2k+1 from bits 31:16.
- R4: `load_done` is high for exactly one cycle, namely the cycle after the clock edge that accepts the final word of a load.
- R5: From reset and after each enable, `px_ready` stays low until the first load completes. At the direct depth it stays low until the first `frame_start`. `wd_ready` and `px_ready` are never high together.
- R6: At the direct depth no load ever occurs. `wd_ready` stays low even with `wd_valid` high, `frame_start` and `reload_req` both asserted.
- R7: While pixels are being accepted at a non-direct depth, a `frame_start` with `reload_req` high begins a new full load. A `frame_start` with `reload_req` low changes nothing.
- R8: A `frame_start` that arrives during a load is ignored, and the load keeps its word count.
- R9: `col_valid` is high in the cycle after each accepted pixel (`px_valid` and `px_ready`) and low otherwise.
- R10: A lookup uses only the low 1, 2, 4 or 8 bits of `px_index` for 1, 2, 4 or 8 bpp. The higher bits have no effect on `col_data`.
- R11: At the direct depth, `col_data` equals the `px_index` that was accepted one cycle earlier.
- R12: Taking `en` low stops both loading and pixel acceptance. After `en` rises again, pixels are refused until a new load completes, even if the depth is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Unit enable (level) |
| depth_sel | input | 3 | Pixel depth code, sampled while disabled |
| frame_start | input | 1 | One-cycle frame boundary strobe |
| reload_req | input | 1 | Requests a palette load at this frame start |
| wd_valid | input | 1 | Palette word valid |
| wd_data | input | 32 | Two palette entries, lower entry in bits 15:0 |
| wd_ready | output | 1 | Palette word accepted this cycle when valid |
| px_valid | input | 1 | Pixel index valid |
| px_index | input | 16 | Encoded pixel, or a direct colour at 16 bpp |
| px_ready | output | 1 | Pixel accepted this cycle when valid |
| col_valid | output | 1 | Colour output valid |
| col_data | output | 16 | Looked-up or passed-through colour |
| load_done | output | 1 | One-cycle pulse when a load completes |

## Verification
Every result of this unit is due at the first sampling point after the clock edge that causes it. A handshake decided at an edge changes `wd_ready` and `px_ready` at that edge. `load_done` follows the edge that takes the last word. `col_valid` and `col_data` follow the edge that accepts the pixel. The bench drives inputs on falling edges and updates its behavioural model on each rising edge from the inputs seen there. It compares every output with the model half a cycle later, so each check lands exactly one edge after its cause.

// File: rtl/pal_pkg.sv
package pal_pkg;

  typedef logic [2:0] depth_t;

  typedef enum logic [1:0] {
    ST_OFF,
    ST_WAIT,
    ST_LOAD,
    ST_RUN
  } ld_state_e;

  // Codes 4..7 select the direct 16-bit mode
  function automatic logic is_direct(input depth_t d);
    return d[2];
  endfunction

  // Words per load: two entries per word
  function automatic int unsigned load_words(input depth_t d);
    case (d)
      3'd0, 3'd1: return 2;
      3'd2:       return 8;
      3'd3:       return 128;
      default:    return 0;
    endcase
  endfunction

  // Index bits that take part in a lookup
  function automatic logic [7:0] idx_mask(input depth_t d);
    case (d)
      3'd0:    return 8'h01;
      3'd1:    return 8'h03;
      3'd2:    return 8'h0F;
      default: return 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/pal_load_ctrl.sv
module pal_load_ctrl
  import pal_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  depth_t           depth_sel,
  input  logic             frame_start,
  input  logic             reload_req,
  input  logic             wd_valid,
  output logic             wd_ready,
  output logic             px_open,
  output depth_t           act_depth,
  output logic             wr_en,
  output logic [CNT_W-1:0] wr_addr,
  output logic             load_done
);

  ld_state_e        st, st_nxt;
  logic [CNT_W-1:0] cnt;
  logic             last_word;

  assign wd_ready  = (st == ST_LOAD);
  assign px_open   = (st == ST_RUN);
  assign wr_en     = wd_valid && wd_ready;
  assign wr_addr   = cnt;
  assign last_word = wr_en && (cnt == CNT_W'(load_words(act_depth) - 1));

  always_comb begin
    st_nxt = st;
    case (st)
      ST_OFF:  st_nxt = ST_WAIT;
      ST_WAIT: if (frame_start) st_nxt = is_direct(act_depth) ? ST_RUN : ST_LOAD;
      ST_LOAD: if (last_word) st_nxt = ST_RUN;
      ST_RUN:  if (frame_start && reload_req && !is_direct(act_depth)) st_nxt = ST_LOAD;
      default: st_nxt = ST_OFF;
    endcase
    if (!en) st_nxt = ST_OFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_OFF;
      act_depth <= '0;
      cnt       <= '0;
      load_done <= 1'b0;
    end else begin
      st        <= st_nxt;
      load_done <= last_word;
      if (!en) act_depth <= depth_sel;
      if (st != ST_LOAD) cnt <= '0;
      else if (wr_en)    cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pal_ram.sv
module pal_ram #(
  parameter int ENTRY_W = 16,
  parameter int DEPTH   = 256,
  localparam int BANK_D = DEPTH / 2,
  localparam int BA_W   = $clog2(BANK_D)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [BA_W-1:0]            wr_addr,
  input  logic [2*ENTRY_W-1:0]       wr_data,
  input  logic                       rd_en,
  input  logic [BA_W-1:0]            rd_addr,
  output logic [1:0][ENTRY_W-1:0]    rd_data
);

  // Bank 0 holds even entries, bank 1 odd entries
  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [ENTRY_W-1:0] mem [BANK_D];

    always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data[b*ENTRY_W +: ENTRY_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data[b] <= '0;
      else if (rd_en) rd_data[b] <= mem[rd_addr];
    end
  end

endmodule

// File: rtl/pal_lookup.sv
module pal_lookup
  import pal_pkg::*;
#(
  parameter int ENTRY_W = 16,
  parameter int ADDR_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    px_acc,
  input  logic [ENTRY_W-1:0]      px_index,
  input  depth_t                  act_depth,
  output logic                    rd_en,
  output logic [ADDR_W-2:0]       rd_addr,
  input  logic [1:0][ENTRY_W-1:0] bank_q,
  output logic                    col_valid,
  output logic [ENTRY_W-1:0]      col_data
);

  logic [ADDR_W-1:0]  idx_m;
  logic               v_q, sel_q, dir_q;
  logic [ENTRY_W-1:0] raw_q;

  assign idx_m   = px_index[ADDR_W-1:0] & ADDR_W'(idx_mask(act_depth));
  assign rd_en   = px_acc && !is_direct(act_depth);
  assign rd_addr = idx_m[ADDR_W-1:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= 1'b0;
      sel_q <= 1'b0;
      dir_q <= 1'b0;
      raw_q <= '0;
    end else begin
      v_q <= px_acc;
      if (px_acc) begin
        sel_q <= idx_m[0];
        dir_q <= is_direct(act_depth);
        raw_q <= px_index;
      end
    end
  end

  assign col_valid = v_q;
  assign col_data  = dir_q ? raw_q : bank_q[sel_q];

endmodule

// File: rtl/pal_lut_unit.sv
module pal_lut_unit
  import pal_pkg::*;
#(
  parameter int ENTRY_W = 16,
  parameter int ENTRIES = 256,
  localparam int ADDR_W = $clog2(ENTRIES),
  localparam int CNT_W  = ADDR_W - 1,
  localparam int WORD_W = 2 * ENTRY_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [2:0]         depth_sel,
  input  logic               frame_start,
  input  logic               reload_req,
  input  logic               wd_valid,
  input  logic [WORD_W-1:0]  wd_data,
  output logic               wd_ready,
  input  logic               px_valid,
  input  logic [ENTRY_W-1:0] px_index,
  output logic               px_ready,
  output logic               col_valid,
  output logic [ENTRY_W-1:0] col_data,
  output logic               load_done
);

  depth_t                  act_depth;
  logic                    wr_en;
  logic [CNT_W-1:0]        wr_addr;
  logic                    px_acc;
  logic                    rd_en;
  logic [CNT_W-1:0]        rd_addr;
  logic [1:0][ENTRY_W-1:0] bank_q;

  assign px_acc = px_valid && px_ready;

  pal_load_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .depth_sel   (depth_sel),
    .frame_start (frame_start),
    .reload_req  (reload_req),
    .wd_valid    (wd_valid),
    .wd_ready    (wd_ready),
    .px_open     (px_ready),
    .act_depth   (act_depth),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .load_done   (load_done)
  );

  pal_ram #(.ENTRY_W(ENTRY_W), .DEPTH(ENTRIES)) u_ram (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wd_data),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (bank_q)
  );

  pal_lookup #(.ENTRY_W(ENTRY_W), .ADDR_W(ADDR_W)) u_lookup (
    .clk       (clk),
    .rst_n     (rst_n),
    .px_acc    (px_acc),
    .px_index  (px_index),
    .act_depth (act_depth),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .bank_q    (bank_q),
    .col_valid (col_valid),
    .col_data  (col_data)
  );

endmodule

// File: rtl/pal_lut_chk.sv
module pal_lut_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic        wd_ready,
  input logic        px_valid,
  input logic        px_ready,
  input logic [15:0] px_index,
  input logic        col_valid,
  input logic [15:0] col_data,
  input logic        load_done,
  input logic [2:0]  act_depth,
  input logic        wr_en
);

  p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wd_ready && px_ready));

  p_col_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && px_ready) |=> col_valid);

  p_col_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(px_valid && px_ready) |=> !col_valid);

  p_direct_noload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    act_depth[2] |-> !wd_ready);

  p_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && px_ready && act_depth[2]) |=> (col_data == $past(px_index)));

  p_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> $past(wr_en));

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> !load_done);

  p_enable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |=> !px_ready);

  p_depth_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |=> $stable(act_depth));

endmodule

bind pal_lut_unit pal_lut_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .wd_ready  (wd_ready),
  .px_valid  (px_valid),
  .px_ready  (px_ready),
  .px_index  (px_index),
  .col_valid (col_valid),
  .col_data  (col_data),
  .load_done (load_done),
  .act_depth (act_depth),
  .wr_en     (wr_en)
);

// File: tb/pal_lut_unit_tb.sv
module pal_lut_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n, en, frame_start, reload_req, wd_valid, px_valid;
  logic [2:0]  depth_sel;
  logic [31:0] wd_data;
  logic [15:0] px_index;
  logic        wd_ready, px_ready, col_valid, load_done;
  logic [15:0] col_data;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  pal_lut_unit u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .depth_sel(depth_sel),
    .frame_start(frame_start), .reload_req(reload_req),
    .wd_valid(wd_valid), .wd_data(wd_data), .wd_ready(wd_ready),
    .px_valid(px_valid), .px_index(px_index), .px_ready(px_ready),
    .col_valid(col_valid), .col_data(col_data), .load_done(load_done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: 0 off, 1 waiting, 2 loading, 3 running
  int          m_state, m_depth, m_cnt;
  bit          m_colv, m_done;
  logic [15:0] m_cold;
  logic [15:0] m_pal [256];

  function automatic bit direct_d(input int d);
    return d >= 4;
  endfunction
  function automatic int entries_of(input int d);
    return 1 << (1 << d);
  endfunction
  function automatic int words_of(input int d);
    return (entries_of(d) / 2 < 2) ? 2 : entries_of(d) / 2;
  endfunction

  always @(posedge clk) begin
    bit acc_w, acc_p;
    if (!rst_n) begin
      m_state = 0; m_depth = 0; m_cnt = 0;
      m_colv = 0; m_done = 0; m_cold = '0;
    end else begin
      acc_w = (m_state == 2) && wd_valid;
      acc_p = (m_state == 3) && px_valid;
      m_done = 0;
      m_colv = acc_p;
      if (acc_p) begin
        if (direct_d(m_depth)) m_cold = px_index;
        else m_cold = m_pal[int'(px_index) % entries_of(m_depth)];
      end
      if (acc_w) begin
        m_pal[2*m_cnt]   = wd_data[15:0];
        m_pal[2*m_cnt+1] = wd_data[31:16];
        m_cnt++;
      end
      if (!en) begin
        if (acc_w && m_cnt == words_of(m_depth)) m_done = 1;
        m_state = 0;
        m_depth = int'(depth_sel);
      end else begin
        case (m_state)
          0: m_state = 1;
          1: if (frame_start) begin
               m_cnt = 0;
               m_state = direct_d(m_depth) ? 3 : 2;
             end
          2: if (acc_w && m_cnt == words_of(m_depth)) begin
               m_done = 1; m_state = 3;
             end
          default: if (frame_start && reload_req && !direct_d(m_depth)) begin
               m_cnt = 0; m_state = 2;
             end
        endcase
      end
    end
  end

  // Compare every cycle, half a cycle after the edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(wd_ready == (m_state == 2), "R2 wd_ready", int'(wd_ready), int'(m_state == 2));
      chk(px_ready == (m_state == 3), "R5 px_ready", int'(px_ready), int'(m_state == 3));
      chk(load_done == m_done, "R4 load_done", int'(load_done), int'(m_done));
      chk(col_valid == m_colv, "R9 col_valid", int'(col_valid), int'(m_colv));
      if (m_colv)
        chk(col_data == m_cold, direct_d(m_depth) ? "R11 col_data" : "R3/R10 col_data",
            int'(col_data), int'(m_cold));
    end
  end

  task automatic pulse_fs(input bit rl);
    @(negedge clk); frame_start = 1; reload_req = rl;
    @(negedge clk); frame_start = 0; reload_req = 0;
  endtask

  task automatic load(input int n, input int seed, input int fs_at);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      wd_valid = 1;
      wd_data  = {8'(seed), 8'(2*k+1), 8'(seed + 1), 8'(2*k)};
      frame_start = (k == fs_at);
      reload_req  = (k == fs_at);
      do @(posedge clk); while (!wd_ready);
      if (k % 3 == 1) begin
        @(negedge clk); wd_valid = 0; frame_start = 0; reload_req = 0;
      end
    end
    @(negedge clk); wd_valid = 0; frame_start = 0; reload_req = 0;
  endtask

  task automatic send_px(input logic [15:0] idx);
    @(negedge clk); px_valid = 1; px_index = idx;
    do @(posedge clk); while (!px_ready);
  endtask

  task automatic idle(input int n);
    @(negedge clk); px_valid = 0; wd_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R9 watchdog expired: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 0; en = 0; frame_start = 0; reload_req = 0;
    wd_valid = 0; wd_data = '0; px_valid = 0; px_index = '0; depth_sel = 3'd0;
    repeat (3) @(negedge clk);
    // Reset state (R5, R9, R4)
    chk(!wd_ready && !px_ready, "R5 reset ready", int'({wd_ready, px_ready}), 0);
    chk(!col_valid && !load_done, "R9 reset outputs", int'({col_valid, load_done}), 0);
    rst_n = 1;

    // R1 R2 R3 R5: 1 bpp, pixels refused before the load
    depth_sel = 3'd0; en = 1;
    @(negedge clk); px_valid = 1; px_index = 16'h0001;
    repeat (3) @(negedge clk);
    px_valid = 0;
    pulse_fs(1'b0);
    load(2, 1, -1);
    // R10: upper index bits set
    for (int i = 0; i < 8; i++) send_px(16'hAB00 | 16'(i));
    idle(1);
    // R7: frame start without reload has no effect
    pulse_fs(1'b0);
    for (int i = 0; i < 4; i++) send_px(16'(i * 3));
    idle(2);

    // R12 R1: disable, 4 bpp, depth change while enabled is ignored
    en = 0; depth_sel = 3'd2;
    repeat (2) @(negedge clk);
    en = 1;
    @(negedge clk); depth_sel = 3'd3;
    @(negedge clk); px_valid = 1; px_index = 16'h0005;
    repeat (2) @(negedge clk);
    px_valid = 0;
    pulse_fs(1'b0);
    load(8, 2, 3);             // R8: frame start mid-load
    for (int i = 0; i < 32; i++) send_px(16'(i * 5 + 16'h1230));
    idle(1);
    // R7: reload at a frame start
    pulse_fs(1'b1);
    load(8, 7, -1);
    for (int i = 0; i < 20; i++) send_px(16'(i));
    idle(2);

    // R12: same depth after re-enable still needs a load; now 8 bpp
    en = 0;
    repeat (2) @(negedge clk);
    en = 1;
    @(negedge clk); px_valid = 1; px_index = 16'h0002;
    @(negedge clk); px_valid = 0;
    pulse_fs(1'b0);
    load(128, 4, -1);
    for (int i = 0; i < 256; i++) send_px(16'(i * 37) ^ 16'hC300);
    idle(2);

    // R6 R11: direct mode (code 7), word stream offered but never taken
    en = 0; depth_sel = 3'd7;
    repeat (2) @(negedge clk);
    en = 1;
    @(negedge clk); wd_valid = 1; wd_data = 32'hDEAD_BEEF;
    pulse_fs(1'b1);
    for (int i = 0; i < 10; i++) send_px(16'hF00D ^ 16'(i * 4099));
    @(negedge clk); frame_start = 1; reload_req = 1;
    @(negedge clk); frame_start = 0; reload_req = 0;
    send_px(16'h1357);
    idle(2);
    chk(!wd_ready, "R6 no load in direct mode", int'(wd_ready), 0);

    // R12: 2 bpp, enable dropped during pixel stream
    en = 0; depth_sel = 3'd1;
    repeat (2) @(negedge clk);
    en = 1;
    pulse_fs(1'b0);
    load(2, 9, -1);
    for (int i = 0; i < 6; i++) send_px(16'hFFF0 | 16'(i));
    @(negedge clk); en = 0; px_valid = 1;
    repeat (2) @(negedge clk);
    chk(!px_ready, "R12 pixels refused when disabled", int'(px_ready), 0);
    idle(3);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule